// File: doc/BRIEF.md
# Stream Buffer Stride Prefetcher

This block sits between the miss path of a first-level cache and the next memory level. When the cache misses on a block address, the prefetcher probes a set of small FIFO stream buffers. If a buffer already holds the block, the block goes to the cache at once and no memory access is made. If a buffer holds a request for the block that has not returned yet, the lookup waits for that request instead of issuing a second one. If no buffer knows the block, the least recently used buffer is restarted at the missed address. A demand request is then sent to memory, and the buffer begins prefetching the blocks that follow.

Each buffer learns a stride from the addresses of the misses it serves. A new stride is adopted only after the same non-zero difference has been seen on two hits in a row. Until then the buffer fetches the following blocks in sequence. Prefetched blocks stay in the buffers and never go to the cache unless a miss asks for them. Memory requests carry an identifier, and responses are matched on it, so responses may return in any order. A response for an entry that has since been discarded is dropped.

Addresses are block addresses, so one address step is one cache block. The number of buffers (1 to 8) and the buffer depth (for example 1, 4 or 16) are parameters.

Top module: `sbuf_prefetch`

## Requirements
- R1: A miss that matches no buffer entry restarts the least recently used buffer at the missed address with a stride of one. It issues a demand request for that address first, and the buffer's first prefetch request follows for address plus one.
- R2: A fill response carries the missed address on fill_addr and that block's memory data on fill_data, pulsed for one cycle on fill_valid. Prefetched blocks never appear on the fill port unless a miss asks for them.
- R3: A miss whose address matches a returned buffer entry is served from the buffer, with fill_valid seen two cycles after acceptance and no memory request for that address.
- R4: A miss whose address matches an entry still waiting on memory waits for that response and issues no second request for the address.
- R5: A buffer hit discards the hit entry and every older entry in that buffer. The buffer then refills, and each new prefetch address is the previous one plus the current stride.
- R6: A stride is adopted only when the same non-zero difference between successive hit addresses occurs twice in a row. Adoption flushes the buffer and restarts prefetching at the hit address plus the new stride. Before that, prefetches stay sequential.
- R7: Buffers are replaced in least-recently-used order, where a buffer counts as used when it is hit or allocated. Right after reset the highest-numbered buffer is the first victim.
- R8: A buffer never holds more than DEPTH entries, so after an allocation exactly DEPTH prefetch requests are issued if no hit intervenes.
- R9: Each memory request carries an identifier from mem_req_id, and responses are matched on mem_rsp_id. A demand request has priority over prefetches, and it is held stable until accepted. A prefetch request is issued only for a buffer that has room.
- R10: After reset, miss_ready is 1, fill_valid is 0 and mem_req_valid is 0.
- R11: One miss is handled at a time: miss_ready stays 0 from the cycle after a miss is accepted until its fill has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| miss_valid | input | 1 | Cache presents a miss |
| miss_ready | output | 1 | Block can accept a miss |
| miss_addr | input | ADDR_W | Block address of the miss |
| fill_valid | output | 1 | One-cycle pulse with the missed block |
| fill_addr | output | ADDR_W | Address of the block being filled |
| fill_data | output | DATA_W | Data of the block being filled |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Block address requested |
| mem_req_id | output | ID_W | Identifier of the request |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_id | input | ID_W | Identifier of the answered request |
| mem_rsp_data | input | DATA_W | Data of the answered request |

## Verification
Directed sequences first check the cold start. One miss must produce the demand request and exactly DEPTH sequential prefetches, and a head hit must produce exactly one refill. A slowed memory exposes the wait-on-pending path, and a duplicate request there is counted as an error. A step of four separates the sequential phase from the adopted stride through the exact request addresses. Four streams followed by a touch and a fifth stream tell least-recently-used replacement apart from fixed or FIFO replacement. Random walks then follow several interleaved streams with mixed steps, jumps and random memory latency. Every fill is checked against the address and a data function. In this phase, flushed entries with responses still in flight show whether stale identifiers are dropped.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_DREQ,
        ST_DWAIT
    } miss_st_e;

    localparam int unsigned SBP_MAX_BUFS = 8;

    function automatic int unsigned ptr_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // distance of slot s behind head h in a ring of d slots
    function automatic int ring_pos(input int s, input int h, input int d);
        return (s + d - h) % d;
    endfunction

endpackage

// File: rtl/sbp_lru.sv
module sbp_lru #(
    parameter int unsigned NUM_BUF = 4,
    localparam int unsigned IW = sbp_pkg::ptr_w(NUM_BUF)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          touch_valid,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] victim
);
    logic [IW-1:0]      rank [NUM_BUF];
    logic [NUM_BUF-1:0] is_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NUM_BUF; b++) rank[b] <= IW'(b);
        end else if (touch_valid) begin
            for (int b = 0; b < NUM_BUF; b++) begin
                if (IW'(b) == touch_idx)
                    rank[b] <= '0;
                else if (rank[b] < rank[touch_idx])
                    rank[b] <= rank[b] + IW'(1);
            end
        end
    end

    always_comb begin
        victim = '0;
        for (int b = 0; b < NUM_BUF; b++) begin
            is_old[b] = (rank[b] == IW'(NUM_BUF - 1));
            if (is_old[b]) victim = IW'(b);
        end
    end

    // R7: the ranks stay a permutation, so exactly one buffer is oldest
    a_r7_one_victim: assert property (@(posedge clk) disable iff (rst)
        $countones(is_old) == 1);

endmodule

// File: rtl/sbp_stream_buf.sv
module sbp_stream_buf #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ID_W   = 6,
    localparam int unsigned PW = sbp_pkg::ptr_w(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic              lk_hit_valid,
    output logic [DATA_W-1:0] lk_data,
    input  logic              do_pop,
    input  logic              do_alloc,
    input  logic [ADDR_W-1:0] alloc_addr,
    output logic              pf_want,
    output logic [ADDR_W-1:0] pf_addr,
    input  logic              pf_grant,
    input  logic [ID_W-1:0]   pf_id,
    input  logic              rsp_valid,
    input  logic [ID_W-1:0]   rsp_id,
    input  logic [DATA_W-1:0] rsp_data
);
    import sbp_pkg::*;

    logic [DEPTH-1:0]  e_vld, e_pnd;
    logic [ADDR_W-1:0] e_addr [DEPTH];
    logic [ID_W-1:0]   e_id   [DEPTH];
    logic [DATA_W-1:0] e_data [DEPTH];

    logic [PW-1:0]     head, tail;
    logic [CW-1:0]     count;
    logic              active;
    logic [ADDR_W-1:0] next_pf, stride, last_addr, last_delta;

    logic [PW-1:0]     hit_slot;
    int                hit_pos;
    logic [ADDR_W-1:0] new_delta;
    logic              confirm;

    // associative match over all live entries
    always_comb begin
        lk_hit   = 1'b0;
        hit_slot = '0;
        for (int s = DEPTH - 1; s >= 0; s--) begin
            if ((e_vld[s] || e_pnd[s]) && e_addr[s] == lk_addr) begin
                lk_hit   = 1'b1;
                hit_slot = PW'(s);
            end
        end
        lk_hit_valid = e_vld[hit_slot];
        lk_data      = e_data[hit_slot];
        hit_pos      = ring_pos(int'(hit_slot), int'(head), int'(DEPTH));
        new_delta    = lk_addr - last_addr;
        confirm      = (new_delta == last_delta) && (new_delta != '0) &&
                       (new_delta != stride);
    end

    assign pf_want = active && (count < CW'(DEPTH));
    assign pf_addr = next_pf;

    always_ff @(posedge clk) begin
        if (rst) begin
            e_vld      <= '0;
            e_pnd      <= '0;
            head       <= '0;
            tail       <= '0;
            count      <= '0;
            active     <= 1'b0;
            next_pf    <= '0;
            stride     <= ADDR_W'(1);
            last_addr  <= '0;
            last_delta <= '0;
        end else begin
            for (int s = 0; s < DEPTH; s++) begin
                if (rsp_valid && e_pnd[s] && e_id[s] == rsp_id) begin
                    e_vld[s]  <= 1'b1;
                    e_pnd[s]  <= 1'b0;
                    e_data[s] <= rsp_data;
                end
            end
            if (do_alloc) begin
                e_vld      <= '0;
                e_pnd      <= '0;
                head       <= '0;
                tail       <= '0;
                count      <= '0;
                active     <= 1'b1;
                stride     <= ADDR_W'(1);
                last_addr  <= alloc_addr;
                last_delta <= '0;
                next_pf    <= alloc_addr + ADDR_W'(1);
            end else if (do_pop) begin
                last_addr  <= lk_addr;
                last_delta <= new_delta;
                if (confirm) begin
                    stride  <= new_delta;
                    next_pf <= lk_addr + new_delta;
                    e_vld   <= '0;
                    e_pnd   <= '0;
                    head    <= tail;
                    count   <= '0;
                end else begin
                    for (int s = 0; s < DEPTH; s++) begin
                        if (ring_pos(s, int'(head), int'(DEPTH)) <= hit_pos) begin
                            e_vld[s] <= 1'b0;
                            e_pnd[s] <= 1'b0;
                        end
                    end
                    head  <= PW'((int'(head) + hit_pos + 1) % int'(DEPTH));
                    count <= count - CW'(hit_pos + 1);
                end
            end else if (pf_grant) begin
                e_pnd[tail]  <= 1'b1;
                e_vld[tail]  <= 1'b0;
                e_addr[tail] <= next_pf;
                e_id[tail]   <= pf_id;
                tail         <= PW'((int'(tail) + 1) % int'(DEPTH));
                count        <= count + CW'(1);
                next_pf      <= next_pf + stride;
            end
        end
    end

    // R8: occupancy is bounded by the depth
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R9: the arbiter grants only a buffer that asked
    a_r9_grant_wanted: assert property (@(posedge clk) disable iff (rst)
        pf_grant |-> pf_want);

    // R1: a restarted buffer is empty and asks for the next block
    a_r1_alloc_restart: assert property (@(posedge clk) disable iff (rst)
        do_alloc |=> (count == '0 && pf_want &&
                      pf_addr == $past(alloc_addr) + ADDR_W'(1)));

endmodule

// File: rtl/sbuf_prefetch.sv
module sbuf_prefetch #(
    parameter int unsigned NUM_BUF = 4,
    parameter int unsigned DEPTH   = 4,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ID_W    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [DATA_W-1:0] fill_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [ID_W-1:0]   mem_req_id,
    input  logic              mem_rsp_valid,
    input  logic [ID_W-1:0]   mem_rsp_id,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    import sbp_pkg::*;

    localparam int unsigned IW = ptr_w(NUM_BUF);

    miss_st_e          state;
    logic [ADDR_W-1:0] cur_addr;
    logic [ID_W-1:0]   dem_id, id_ctr;

    logic [NUM_BUF-1:0] buf_hit, buf_hit_vld, pf_want, grant, pop, alloc;
    logic [DATA_W-1:0]  buf_data [NUM_BUF];
    logic [ADDR_W-1:0]  pf_addr  [NUM_BUF];

    logic          sel_found, pf_found, pf_allowed, touch_valid;
    logic [IW-1:0] sel_idx, pf_idx, victim, touch_idx;

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
        sbp_stream_buf #(
            .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)
        ) u_buf (
            .clk          (clk),
            .rst          (rst),
            .lk_addr      (cur_addr),
            .lk_hit       (buf_hit[b]),
            .lk_hit_valid (buf_hit_vld[b]),
            .lk_data      (buf_data[b]),
            .do_pop       (pop[b]),
            .do_alloc     (alloc[b]),
            .alloc_addr   (cur_addr),
            .pf_want      (pf_want[b]),
            .pf_addr      (pf_addr[b]),
            .pf_grant     (grant[b]),
            .pf_id        (id_ctr),
            .rsp_valid    (mem_rsp_valid),
            .rsp_id       (mem_rsp_id),
            .rsp_data     (mem_rsp_data)
        );
    end

    sbp_lru #(.NUM_BUF(NUM_BUF)) u_lru (
        .clk         (clk),
        .rst         (rst),
        .touch_valid (touch_valid),
        .touch_idx   (touch_idx),
        .victim      (victim)
    );

    // lowest-numbered matching buffer and lowest-numbered hungry buffer
    always_comb begin
        sel_found = 1'b0;
        sel_idx   = '0;
        pf_found  = 1'b0;
        pf_idx    = '0;
        for (int b = NUM_BUF - 1; b >= 0; b--) begin
            if (buf_hit[b]) begin
                sel_found = 1'b1;
                sel_idx   = IW'(b);
            end
            if (pf_want[b]) begin
                pf_found = 1'b1;
                pf_idx   = IW'(b);
            end
        end
    end

    assign miss_ready = (state == ST_IDLE);
    assign pf_allowed = (state == ST_IDLE) || (state == ST_DWAIT);
    assign mem_req_id = id_ctr;

    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_addr  = cur_addr;
        if (state == ST_DREQ) begin
            mem_req_valid = 1'b1;
        end else if (pf_allowed && pf_found) begin
            mem_req_valid = 1'b1;
            mem_req_addr  = pf_addr[pf_idx];
        end
    end

    always_comb begin
        for (int b = 0; b < NUM_BUF; b++) begin
            grant[b] = pf_allowed && pf_found && pf_idx == IW'(b) && mem_req_ready;
            pop[b]   = (state == ST_LOOK) && sel_found && sel_idx == IW'(b) &&
                       buf_hit_vld[b];
            alloc[b] = (state == ST_LOOK) && !sel_found && victim == IW'(b);
        end
        touch_valid = (state == ST_LOOK) &&
                      (!sel_found || buf_hit_vld[sel_idx]);
        touch_idx   = sel_found ? sel_idx : victim;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur_addr   <= '0;
            dem_id     <= '0;
            id_ctr     <= '0;
            fill_valid <= 1'b0;
            fill_addr  <= '0;
            fill_data  <= '0;
        end else begin
            fill_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) id_ctr <= id_ctr + ID_W'(1);
            unique case (state)
                ST_IDLE: if (miss_valid) begin
                    cur_addr <= miss_addr;
                    state    <= ST_LOOK;
                end
                ST_LOOK: begin
                    if (sel_found) begin
                        if (buf_hit_vld[sel_idx]) begin
                            fill_valid <= 1'b1;
                            fill_addr  <= cur_addr;
                            fill_data  <= buf_data[sel_idx];
                            state      <= ST_IDLE;
                        end
                    end else begin
                        state <= ST_DREQ;
                    end
                end
                ST_DREQ: if (mem_req_ready) begin
                    dem_id <= id_ctr;
                    state  <= ST_DWAIT;
                end
                ST_DWAIT: if (mem_rsp_valid && mem_rsp_id == dem_id) begin
                    fill_valid <= 1'b1;
                    fill_addr  <= cur_addr;
                    fill_data  <= mem_rsp_data;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: quiet after reset
    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> (miss_ready && !fill_valid && !mem_req_valid));

    // R11: an accepted miss closes the port
    a_r11_busy: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_ready) |=> !miss_ready);

    // R11: a fill is a single-cycle pulse
    a_r11_one_fill: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> !fill_valid);

    // R9: a stalled demand request holds its address
    a_r9_demand_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DREQ && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr)));

endmodule

// File: tb/sbuf_prefetch_bench.sv
module sbuf_prefetch_bench;
    localparam int NB = 4;
    localparam int DP = 4;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int IDW = 6;
    localparam int QN = 64;
    localparam int LOGN = 4096;
    localparam int WD = 150000;

    logic clk = 1'b0;
    logic rst;
    logic miss_valid, miss_ready;
    logic [AW-1:0] miss_addr;
    logic fill_valid;
    logic [AW-1:0] fill_addr;
    logic [DW-1:0] fill_data;
    logic mem_req_valid;
    logic mem_req_ready = 1'b1;
    logic [AW-1:0] mem_req_addr;
    logic [IDW-1:0] mem_req_id;
    logic mem_rsp_valid = 1'b0;
    logic [IDW-1:0] mem_rsp_id = '0;
    logic [DW-1:0] mem_rsp_data = '0;

    always #5 clk = ~clk;

    sbuf_prefetch #(.NUM_BUF(NB), .DEPTH(DP), .ADDR_W(AW), .DATA_W(DW), .ID_W(IDW))
    u_sbuf_prefetch (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_id(mem_req_id),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_id(mem_rsp_id),
        .mem_rsp_data(mem_rsp_data)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    function automatic logic [DW-1:0] memdata(input logic [AW-1:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    // memory model
    logic [AW-1:0]  q_addr [QN];
    logic [IDW-1:0] q_id   [QN];
    int             q_due  [QN];
    int qh = 0, qt = 0, last_due = 0;
    int lat = 3;
    bit rand_lat = 0;
    logic [AW-1:0] req_log [LOGN];
    int req_cnt = 0;

    task automatic report_end();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(negedge clk) begin
        int lt;
        mem_rsp_valid = 1'b0;
        if (rst) begin
            qh = qt;
        end else begin
            if (qh != qt && q_due[qh % QN] <= cyc) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_id    = q_id[qh % QN];
                mem_rsp_data  = memdata(q_addr[qh % QN]);
                qh++;
            end
            if (mem_req_valid && mem_req_ready) begin
                lt = rand_lat ? 1 + int'($urandom % 6) : lat;
                last_due = (cyc + lt > last_due) ? cyc + lt : last_due;
                q_addr[qt % QN] = mem_req_addr;
                q_id[qt % QN]   = mem_req_id;
                q_due[qt % QN]  = last_due;
                qt++;
                req_log[req_cnt % LOGN] = mem_req_addr;
                req_cnt++;
            end
        end
        cyc++;
        if (cyc > WD) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WD);
            report_end();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int n_req_of(input int from, input logic [AW-1:0] a);
        int n = 0;
        for (int i = from; i < req_cnt; i++)
            if (req_log[i % LOGN] == a) n++;
        return n;
    endfunction

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
    endtask

    logic [AW-1:0] got_addr;
    logic [DW-1:0] got_data;
    int got_lat;

    // present one miss, wait for its fill, check address and data (R2)
    task automatic do_miss(input logic [AW-1:0] a);
        @(negedge clk);
        miss_valid = 1'b1;
        miss_addr  = a;
        while (!miss_ready) @(negedge clk);
        @(negedge clk);
        miss_valid = 1'b0;
        got_lat = 1;
        while (!fill_valid && got_lat < 500) begin
            @(negedge clk);
            got_lat++;
        end
        got_addr = fill_addr;
        got_data = fill_data;
        chk(fill_valid, "R2 fill given", 64'(fill_valid), 64'd1);
        chk(got_addr == a, "R2 fill address", 64'(got_addr), 64'(a));
        chk(got_data == memdata(a), "R2 fill data", 64'(got_data), 64'(memdata(a)));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        miss_valid = 1'b0;
        miss_addr = '0;
        settle(4);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int r0, r1, hits;
        logic [AW-1:0] cur [4];
        int step [4];
        void'($urandom(32'd20240611));

        do_reset();
        // R10 reset state
        chk(miss_ready == 1'b1, "R10 miss_ready", 64'(miss_ready), 64'd1);
        chk(fill_valid == 1'b0, "R10 fill_valid", 64'(fill_valid), 64'd0);
        chk(mem_req_valid == 1'b0, "R10 mem_req_valid", 64'(mem_req_valid), 64'd0);

        // R1 / R8: cold miss, demand first then DEPTH sequential prefetches
        r0 = req_cnt;
        do_miss(32'h1000);
        chk(got_lat > 2, "R1 cold miss goes to memory", 64'(got_lat), 64'd3);
        settle(30);
        chk(req_cnt - r0 == 1 + DP, "R8 request count after alloc", 64'(req_cnt - r0), 64'(1 + DP));
        chk(req_log[r0 % LOGN] == 32'h1000, "R1 demand first", 64'(req_log[r0 % LOGN]), 64'h1000);
        chk(req_log[(r0 + 1) % LOGN] == 32'h1001, "R1 next block prefetched",
            64'(req_log[(r0 + 1) % LOGN]), 64'h1001);
        chk(req_log[(r0 + DP) % LOGN] == 32'h1000 + DP, "R8 last prefetch",
            64'(req_log[(r0 + DP) % LOGN]), 64'(32'h1000 + DP));

        // R3 / R5: head hit served from buffer, one refill at +stride
        r0 = req_cnt;
        do_miss(32'h1001);
        chk(got_lat == 2, "R3 hit latency", 64'(got_lat), 64'd2);
        settle(30);
        chk(n_req_of(r0, 32'h1001) == 0, "R3 no memory request on hit",
            64'(n_req_of(r0, 32'h1001)), 64'd0);
        chk(req_cnt - r0 == 1, "R5 one refill after head hit", 64'(req_cnt - r0), 64'd1);
        chk(req_log[r0 % LOGN] == 32'h1005, "R5 refill address",
            64'(req_log[r0 % LOGN]), 64'h1005);

        // R4: hit on an entry still in flight waits, no duplicate request
        do_miss(32'h2000);
        settle(30);
        lat = 40;
        r0 = req_cnt;
        do_miss(32'h2001);
        chk(got_lat == 2, "R3 hit latency second stream", 64'(got_lat), 64'd2);
        do_miss(32'h2005);
        chk(got_lat > 20, "R4 waits for pending fill", 64'(got_lat), 64'd40);
        chk(n_req_of(r0, 32'h2005) == 1, "R4 single request for pending block",
            64'(n_req_of(r0, 32'h2005)), 64'd1);
        settle(80);
        lat = 3;

        // R6: stride of four adopted only after the second equal delta
        do_miss(32'h3000);
        settle(30);
        r1 = req_cnt;
        do_miss(32'h3004);
        chk(got_lat == 2, "R5 hit deeper in buffer", 64'(got_lat), 64'd2);
        settle(30);
        chk(req_cnt - r1 == DP, "R6 refill count before adoption", 64'(req_cnt - r1), 64'(DP));
        for (int i = 0; i < DP; i++)
            chk(req_log[(r1 + i) % LOGN] == 32'h3005 + i, "R6 still sequential",
                64'(req_log[(r1 + i) % LOGN]), 64'(32'h3005 + i));
        r1 = req_cnt;
        do_miss(32'h3008);
        settle(30);
        chk(req_cnt - r1 == DP, "R6 refill count after adoption", 64'(req_cnt - r1), 64'(DP));
        for (int i = 0; i < DP; i++)
            chk(req_log[(r1 + i) % LOGN] == 32'h300C + 4 * i, "R6 strided prefetch",
                64'(req_log[(r1 + i) % LOGN]), 64'(32'h300C + 4 * i));
        r1 = req_cnt;
        do_miss(32'h300C);
        chk(got_lat == 2, "R6 strided hit", 64'(got_lat), 64'd2);
        settle(30);
        chk(req_cnt - r1 == 1 && req_log[r1 % LOGN] == 32'h301C, "R5 refill at plus stride",
            64'(req_log[r1 % LOGN]), 64'h301C);
        settle(60);

        // R7: least recently used replacement
        do_reset();
        do_miss(32'h4000); settle(30);
        do_miss(32'h5000); settle(30);
        do_miss(32'h6000); settle(30);
        do_miss(32'h7000); settle(30);
        do_miss(32'h4001);
        chk(got_lat == 2, "R7 first stream still held", 64'(got_lat), 64'd2);
        settle(30);
        do_miss(32'h8000); settle(30);
        r0 = req_cnt;
        do_miss(32'h7001);
        chk(got_lat == 2 && n_req_of(r0, 32'h7001) == 0, "R7 recent stream kept",
            64'(got_lat), 64'd2);
        settle(30);
        r0 = req_cnt;
        do_miss(32'h5001);
        chk(n_req_of(r0, 32'h5001) == 1, "R7 oldest stream evicted",
            64'(n_req_of(r0, 32'h5001)), 64'd1);
        settle(30);
        r0 = req_cnt;
        do_miss(32'h4002);
        chk(got_lat == 2 && n_req_of(r0, 32'h4002) == 0, "R7 touched stream survives",
            64'(got_lat), 64'd2);
        settle(30);

        // R2 / R3 / R9: random interleaved streams, random latency
        rand_lat = 1;
        hits = 0;
        for (int s = 0; s < 4; s++) begin
            cur[s]  = 32'h10000 * (s + 1);
            step[s] = 1 + (s % 3);
        end
        for (int n = 0; n < 200; n++) begin
            int s;
            s = int'($urandom % 4);
            if ($urandom % 10 == 0) cur[s] = 32'h10000 * (s + 1) + ($urandom % 32'h800);
            else cur[s] = cur[s] + step[s];
            do_miss(cur[s]);
            if (got_lat == 2) hits++;
        end
        chk(hits >= 10, "R3 random walks hit in buffers", 64'(hits), 64'd10);
        settle(60);

        report_end();
    end
endmodule